// File: doc/BRIEF.md
# Pseudo-Random Self-Test Controller for a Serial-Weight Dot-Product Unit

This block sits in front of a dot-product unit that takes a parallel data vector and a serially loaded weight word. In normal mode the external data vector, weight bit and the two section enables pass straight through to the unit. In self-test mode a 6-bit linear feedback shift register replaces every stimulus. For each pattern the controller raises the weight-shift enable for a fixed number of cycles, feeding one generated bit per cycle. It then raises the evaluation enable for one cycle, and the unit's one-bit result is folded into a 6-bit single-input signature register.

After a fixed number of patterns both enables drop and stay low, so the tested logic and the signature freeze. The controller then raises done together with exactly one of pass or fail. Pass means the signature equals a golden constant set at build time.

Top module: `bist_ctrl`

## Requirements
- R1: With mode_i low, u_o, w_o, w_shift_en_o and eval_en_o equal ext_u_i, ext_w_i, ext_shift_en_i and ext_eval_en_i, and done_o, pass_o and fail_o are low.
- R2: The generator uses feedback polynomial x^6+x^5+1. The state shifts left with new bit0 = state[5] xor state[4], and it reseeds to 000001 when a test starts. During a test u_o shows the state and w_o shows state bit 0. The state steps once per active cycle, whether load or evaluation.
- R3: During a test each pattern consists of 8 cycles with w_shift_en_o high and eval_en_o low, followed by 1 cycle with eval_en_o high and w_shift_en_o low. The two enables are never high together in self-test mode, and both are low while idle.
- R4: After 16 patterns (144 active cycles), done_o is high from the cycle after the last evaluation. From then on both enables stay low and u_o no longer changes.
- R5: The signature register is 6 bits wide and clears to zero at test start. On each evaluation cycle it shifts left with new bit0 = sig[5] xor sig[4] xor result_i.
- R6: pass_o and fail_o are never high together, neither is high without done_o, and pass_o is high with done_o exactly when the signature equals GOLDEN.
- R7: A change of mode_i returns the controller to idle on the next clock edge. This clears done_o, pass_o and fail_o and abandons any test in progress.
- R8: start_i is accepted only while idle or done in self-test mode. A start pulse during a running test does not change its timing or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 normal, 1 self-test |
| start_i | input | 1 | Start a self-test |
| ext_u_i | input | W | External parallel data vector |
| ext_w_i | input | 1 | External serial weight bit |
| ext_shift_en_i | input | 1 | External weight-shift enable |
| ext_eval_en_i | input | 1 | External evaluation enable |
| result_i | input | 1 | Result bit from the dot-product unit |
| u_o | output | W | Data vector to the unit |
| w_o | output | 1 | Serial weight bit to the unit |
| w_shift_en_o | output | 1 | Weight path clock enable |
| eval_en_o | output | 1 | Evaluation path clock enable |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |

## Verification
The assertions assume that mode_i is driven synchronously and that result_i is valid during any cycle in which eval_en_o is high, since the unit evaluates combinationally from its loaded weights and u_o. The bench holds mode_i steady for at least two cycles before it pulses start, drives every input on the falling edge, and models the unit as a registered 8-bit weight shifter with a parity result. The golden value is derived from that model at elaboration. A second run inverts the model's result to force a mismatch.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EVAL, ST_DONE} bist_state_e;

  function automatic logic lfsr_fb(input logic [15:0] s, input logic [15:0] poly);
    return ^(s & poly);
  endfunction
endpackage

// File: rtl/bist_prsg.sv
module bist_prsg #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] POLY = 6'b110000,
  parameter logic [W-1:0] SEED = 6'b000001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb = bist_pkg::lfsr_fb(16'(s_q), 16'(POLY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (seed_i) s_q <= SEED;
    else if (step_i) s_q <= {s_q[W-2:0], fb};
  end

  assign state_o = s_q;
endmodule

// File: rtl/bist_sisr.sv
module bist_sisr #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] POLY = 6'b110000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q;
  logic         fb;

  assign fb = bist_pkg::lfsr_fb(16'(sig_q), 16'(POLY)) ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= '0;
    else if (clr_i)   sig_q <= '0;
    else if (shift_i) sig_q <= {sig_q[W-2:0], fb};
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/bist_seq.sv
module bist_seq #(
  parameter int unsigned W_CYC = 8,
  parameter int unsigned N_PAT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic start_i,
  output logic go_o,
  output logic load_o,
  output logic eval_o,
  output logic done_o
);
  import bist_pkg::*;
  localparam int unsigned CNT_W = $clog2(W_CYC + 1);
  localparam int unsigned PAT_W = $clog2(N_PAT + 1);

  bist_state_e      state_q;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAT_W-1:0] pat_q;
  logic             mode_chg;

  assign mode_chg = mode_i ^ mode_q;
  assign go_o = mode_i && start_i && !mode_chg &&
                (state_q == ST_IDLE || state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pat_q   <= '0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE, ST_DONE: if (go_o) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            pat_q   <= '0;
          end
          ST_LOAD: begin
            if (cnt_q == CNT_W'(W_CYC - 1)) state_q <= ST_EVAL;
            else                            cnt_q   <= cnt_q + 1'b1;
          end
          ST_EVAL: begin
            if (pat_q == PAT_W'(N_PAT - 1)) begin
              state_q <= ST_DONE;
            end else begin
              pat_q   <= pat_q + 1'b1;
              cnt_q   <= '0;
              state_q <= ST_LOAD;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign load_o = (state_q == ST_LOAD);
  assign eval_o = (state_q == ST_EVAL);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl #(
  parameter int unsigned W      = 6,
  parameter logic [W-1:0] POLY   = 6'b110000,
  parameter logic [W-1:0] SEED   = 6'b000001,
  parameter int unsigned W_CYC  = 8,
  parameter int unsigned N_PAT  = 16,
  parameter logic [W-1:0] GOLDEN = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         start_i,
  input  logic [W-1:0] ext_u_i,
  input  logic         ext_w_i,
  input  logic         ext_shift_en_i,
  input  logic         ext_eval_en_i,
  input  logic         result_i,
  output logic [W-1:0] u_o,
  output logic         w_o,
  output logic         w_shift_en_o,
  output logic         eval_en_o,
  output logic         done_o,
  output logic         pass_o,
  output logic         fail_o
);
  logic         go, load, eval, done;
  logic [W-1:0] prsg_s, sig;

  bist_seq #(.W_CYC(W_CYC), .N_PAT(N_PAT)) u_seq (
    .clk_i, .rst_ni, .mode_i, .start_i,
    .go_o(go), .load_o(load), .eval_o(eval), .done_o(done)
  );

  bist_prsg #(.W(W), .POLY(POLY), .SEED(SEED)) u_prsg (
    .clk_i, .rst_ni, .seed_i(go), .step_i(mode_i & (load | eval)),
    .state_o(prsg_s)
  );

  bist_sisr #(.W(W), .POLY(POLY)) u_sisr (
    .clk_i, .rst_ni, .clr_i(go), .shift_i(mode_i & eval),
    .bit_i(result_i), .sig_o(sig)
  );

  always_comb begin
    if (mode_i) begin
      u_o          = prsg_s;
      w_o          = prsg_s[0];
      w_shift_en_o = load;
      eval_en_o    = eval;
    end else begin
      u_o          = ext_u_i;
      w_o          = ext_w_i;
      w_shift_en_o = ext_shift_en_i;
      eval_en_o    = ext_eval_en_i;
    end
  end

  assign done_o = done;
  assign pass_o = done & (sig == GOLDEN);
  assign fail_o = done & (sig != GOLDEN);
endmodule

// File: rtl/bist_ctrl_chk.sv
module bist_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic w_shift_en_o,
  input logic eval_en_o,
  input logic done_o,
  input logic pass_o,
  input logic fail_o
);
  AST_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !(w_shift_en_o && eval_en_o)); // R3
  AST_EVAL_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && eval_en_o) |-> $past(w_shift_en_o)); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && done_o) |-> (!w_shift_en_o && !eval_en_o)); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R6
  AST_FLAG_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> done_o); // R6
  AST_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i)) |=> !done_o); // R7
endmodule

bind bist_ctrl bist_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .w_shift_en_o(w_shift_en_o), .eval_en_o(eval_en_o),
  .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/bist_ctrl_test.sv
`timescale 1ns/1ps
module bist_ctrl_test;
  function automatic logic [5:0] nxt(input logic [5:0] s, input logic b);
    return {s[4:0], s[5] ^ s[4] ^ b};
  endfunction

  function automatic logic model_res(input logic [7:0] wr, input logic [5:0] u);
    return (^(wr[5:0] & u)) ^ wr[7];
  endfunction

  function automatic logic [5:0] calc_sig(input logic inj);
    logic [5:0] s, sig;
    logic [7:0] wr;
    s = 6'b000001; sig = '0; wr = '0;
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 8; i++) begin
        wr = {wr[6:0], s[0]};
        s = nxt(s, 1'b0);
      end
      sig = nxt(sig, model_res(wr, s) ^ inj);
      s = nxt(s, 1'b0);
    end
    return sig;
  endfunction

  localparam logic [5:0] GOLD   = calc_sig(1'b0);
  localparam logic [5:0] GOLD_X = calc_sig(1'b1);

  logic clk = 0, rst_n = 0, mode = 0, start = 0;
  logic [5:0] ext_u = '0;
  logic ext_w = 0, ext_sh = 0, ext_ev = 0, inj = 0;
  logic [5:0] u;
  logic w, sh, ev, done, pass, fail, res;
  logic [7:0] wreg;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wreg <= '0;
    else if (sh) wreg <= {wreg[6:0], w};

  assign res = model_res(wreg, u) ^ inj;

  bist_ctrl #(.GOLDEN(GOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_i(start),
    .ext_u_i(ext_u), .ext_w_i(ext_w), .ext_shift_en_i(ext_sh), .ext_eval_en_i(ext_ev),
    .result_i(res), .u_o(u), .w_o(w), .w_shift_en_o(sh), .eval_en_o(ev),
    .done_o(done), .pass_o(pass), .fail_o(fail)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // {u, w, shift_en, eval_en}
  localparam logic [8:0] NORM_VEC [4] = '{9'b101101_1_1_0, 9'b010010_0_0_1,
                                          9'b111111_1_1_1, 9'b000000_0_0_0};

  // Run one full test; start pulse mid-run checks R8.
  task automatic run_test(input logic exp_pass);
    logic [5:0] s;
    s = 6'b000001;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 144; k++) begin
      if (k == 50) start = 1;
      if (k == 51) start = 0;
      chk(sh == (k % 9 != 8) && ev == (k % 9 == 8), "R3 enables", {14'd0, sh, ev},
          {14'd0, k % 9 != 8, k % 9 == 8});
      chk(u == s && w == s[0], "R2 prsg", {9'd0, u, w}, {9'd0, s, s[0]});
      chk(!done, "R4 early done", 16'(done), 16'd0);
      s = nxt(s, 1'b0);
      @(negedge clk);
    end
    chk(done, "R4 done", 16'(done), 16'd1);
    chk(pass == exp_pass && fail == !exp_pass, "R5 R6 verdict", {14'd0, pass, fail},
        {14'd0, exp_pass, !exp_pass});
    repeat (5) @(negedge clk);
    chk(done && !sh && !ev && u == s, "R4 frozen", {8'd0, done, sh, ev, 1'b0, u[3:0]},
        {8'd0, 1'b1, 1'b0, 1'b0, 1'b0, s[3:0]});
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && !fail, "R6 reset flags", {13'd0, done, pass, fail}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      {ext_u, ext_w, ext_sh, ext_ev} = NORM_VEC[i];
      #1;
      chk({u, w, sh, ev} == NORM_VEC[i], "R1 passthrough", {7'd0, u, w, sh, ev}, {7'd0, NORM_VEC[i]});
      chk(!done && !pass && !fail, "R1 flags", {13'd0, done, pass, fail}, 16'd0);
      @(negedge clk);
    end
    {ext_u, ext_w, ext_sh, ext_ev} = '0;
    mode = 1;
    repeat (3) @(negedge clk);
    chk(!sh && !ev && !done, "R3 idle", {13'd0, sh, ev, done}, 16'd0);

    run_test(GOLD == GOLD);
    inj = 1;
    run_test(GOLD_X == GOLD);
    inj = 0;

    mode = 0;
    @(negedge clk);
    chk(!done && !pass && !fail, "R7 mode exit", {13'd0, done, pass, fail}, 16'd0);
    mode = 1;
    repeat (2) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    mode = 0; @(negedge clk);
    mode = 1;
    repeat (200) @(negedge clk);
    chk(!done && !sh && !ev, "R7 abort", {13'd0, done, sh, ev}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule